// File: doc/BRIEF.md
# Crypto-Extended 16-bit ALU

This block is the combinational arithmetic, logic and shift unit of a small single-cycle processor core. It takes two 16-bit operands, a 5-bit operation code and a 4-bit shift distance. In the same cycle it returns a 16-bit result and three flags: overflow, zero and carry. Besides signed general-purpose arithmetic, bitwise logic and a barrel shifter, it offers the modular operations used by a 64-bit block cipher with 16-bit words: addition modulo 2^16, the additive inverse modulo 2^16, and multiplication modulo 2^16+1 in which a zero word stands for 2^16.

The unit holds no state. The decoder in front of it drives the operation code, and the register write-back path behind it consumes the result in the same cycle. All ports are plain data or control pins, so there is no handshake. Codes 26 to 31 are not implemented. They yield a zero result with overflow and carry clear.

Top module: `alu16_crypto`

## Requirements
- R1: Codes 0 (A+B), 1 (A-1), 2 (A-B) and 3 (A+1) are signed 16-bit operations. Overflow is set when the true result lies outside -32768..+32767. Carry is the carry out of bit 15 for codes 0 and 3, and the unsigned borrow for codes 1 and 2.
- R2: Code 4 returns (A+B) mod 2^16. It never sets overflow, and carry is the discarded bit 16.
- R3: Code 5 returns (2^16 - B) mod 2^16 with overflow and carry clear, so B = 0000h gives 0000h.
- R4: Code 6 returns the low 16 bits of the signed product A*B. Overflow is set when the full product lies outside -32768..+32767.
- R5: Code 7 returns (A*B) mod 65537, with an operand of 0000h taken as 65536 and a modular result of 65536 returned as 0000h. Overflow is never set.
- R6: Code 8 returns the signed quotient truncated toward zero, and code 9 returns the remainder, which takes the sign of A. With B = 0, code 8 returns FFFFh, code 9 returns A, and both set overflow. Code 8 with -32768 / -1 returns 8000h with overflow set.
- R7: Codes 10 (logical left) and 11 (logical right) shift B by the shift amount. Carry is the last bit shifted out, or 0 when the amount is 0.
- R8: Codes 12 (rotate left) and 13 (rotate right) rotate B by the shift amount, and carry is always 0.
- R9: Code 14 (arithmetic left) shifts B left and sets overflow when the signed value B*2^amount does not fit in 16 bits, with carry as in R7. Code 15 (arithmetic right) replicates the sign bit, and its carry is the last bit shifted out.
- R10: Codes 16 to 23 return A, NOT A, A AND B, A NAND B, A OR B, A NOR B, A XOR B and A XNOR B.
- R11: Code 24 returns FFFFh when A < B as signed numbers and 0000h otherwise. The decision is the sign of A-B XOR the overflow of A-B, and overflow is left clear.
- R12: Code 25 returns A-B with overflow always clear, and carry is the unsigned borrow.
- R13: Codes 26 to 31 return 0000h with overflow and carry clear.
- R14: The zero flag is high exactly when the result is 0000h, for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B (the shifted operand for codes 10-15) |
| op_i | input | 5 | Operation code |
| shamt_i | input | 4 | Shift or rotate distance, 0 to 15 |
| result_o | output | 16 | Operation result |
| ovf_o | output | 1 | Signed overflow or divide-by-zero flag |
| zero_o | output | 1 | Result equals 0000h |
| carry_o | output | 1 | Carry, borrow or last bit shifted out |

## Verification
The zero flag is derived from the result of every function, so it can rise in the same cycle as overflow or carry. Signed multiplication of 0100h by 0100h provokes zero together with overflow, and modular addition of 8000h and 8000h provokes zero together with carry. In both cases the three flags are read as a triple against hand-computed values. The modular multiplier is judged in the same way on its wrap corner, where 8000h times 2 reduces to 65536 and must appear as a zero result with overflow clear.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [4:0] {
    OP_ADD    = 5'd0,  OP_DEC   = 5'd1,  OP_SUB   = 5'd2,  OP_INC   = 5'd3,
    OP_ADDM   = 5'd4,  OP_ADINV = 5'd5,  OP_MUL   = 5'd6,  OP_MULM  = 5'd7,
    OP_DIV    = 5'd8,  OP_REM   = 5'd9,  OP_SHL   = 5'd10, OP_SHR   = 5'd11,
    OP_ROL    = 5'd12, OP_ROR   = 5'd13, OP_ASHL  = 5'd14, OP_ASHR  = 5'd15,
    OP_PASS   = 5'd16, OP_NOT   = 5'd17, OP_AND   = 5'd18, OP_NAND  = 5'd19,
    OP_OR     = 5'd20, OP_NOR   = 5'd21, OP_XOR   = 5'd22, OP_XNOR  = 5'd23,
    OP_SLT    = 5'd24, OP_CMP   = 5'd25
  } alu_op_e;

  typedef enum logic [1:0] {U_ARITH, U_SHIFT, U_LOGIC, U_NONE} alu_unit_e;

  function automatic alu_unit_e unit_of(input logic [4:0] op);
    if (op <= 5'd9 || op == 5'd24 || op == 5'd25) return U_ARITH;
    else if (op <= 5'd15)                         return U_SHIFT;
    else if (op <= 5'd23)                         return U_LOGIC;
    else                                          return U_NONE;
  endfunction
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [4:0]   op,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         cy
);
  localparam int PW = 2 * W;
  localparam int MW = 2 * W + 2;
  localparam logic [W-1:0]  ALL1 = '1;
  localparam logic [MW-1:0] MODV = (MW'(1) << W) + MW'(1);

  logic [W:0] sum_ab, dif_ab, inc_a, dec_a;
  logic       v_add, v_sub, lt;
  logic signed [PW-1:0] sa, sb, prod;
  logic       mul_ovf;
  logic [W:0] ma, mb;
  logic [MW-1:0] mp;
  logic [W-1:0]  mulm_res;
  logic signed [W:0] da, db, quo;
  logic [W-1:0] rem_v;
  logic       div0, q_ovf;

  assign sum_ab = {1'b0, a} + {1'b0, b};
  assign dif_ab = {1'b0, a} - {1'b0, b};
  assign inc_a  = {1'b0, a} + {{W{1'b0}}, 1'b1};
  assign dec_a  = {1'b0, a} - {{W{1'b0}}, 1'b1};
  assign v_add  = (a[W-1] == b[W-1]) && (sum_ab[W-1] != a[W-1]);
  assign v_sub  = (a[W-1] != b[W-1]) && (dif_ab[W-1] != a[W-1]);
  assign lt     = dif_ab[W-1] ^ v_sub;

  // signed product, overflow when the upper half is not a sign extension
  assign sa      = {{W{a[W-1]}}, a};
  assign sb      = {{W{b[W-1]}}, b};
  assign prod    = sa * sb;
  assign mul_ovf = !((&prod[PW-1:W-1]) || !(|prod[PW-1:W-1]));

  // modulo 2^W+1 product, zero operand stands for 2^W
  assign ma       = (a == '0) ? {1'b1, {W{1'b0}}} : {1'b0, a};
  assign mb       = (b == '0) ? {1'b1, {W{1'b0}}} : {1'b0, b};
  assign mp       = {{(W+1){1'b0}}, ma} * {{(W+1){1'b0}}, mb};
  assign mulm_res = W'(mp % MODV);

  // signed division in W+1 bits so -2^(W-1) / -1 is representable
  assign div0  = (b == '0);
  assign da    = {a[W-1], a};
  assign db    = div0 ? {{W{1'b0}}, 1'b1} : {b[W-1], b};
  assign quo   = da / db;
  assign rem_v = W'(da % db);
  assign q_ovf = quo[W] != quo[W-1];

  always_comb begin
    res = '0; ovf = 1'b0; cy = 1'b0;
    unique case (op)
      OP_ADD:   begin res = sum_ab[W-1:0]; ovf = v_add; cy = sum_ab[W]; end
      OP_DEC:   begin res = dec_a[W-1:0]; ovf = (a == {1'b1, {(W-1){1'b0}}}); cy = dec_a[W]; end
      OP_SUB:   begin res = dif_ab[W-1:0]; ovf = v_sub; cy = dif_ab[W]; end
      OP_INC:   begin res = inc_a[W-1:0]; ovf = (a == {1'b0, {(W-1){1'b1}}}); cy = inc_a[W]; end
      OP_ADDM:  begin res = sum_ab[W-1:0]; cy = sum_ab[W]; end
      OP_ADINV: res = '0 - b;
      OP_MUL:   begin res = prod[W-1:0]; ovf = mul_ovf; end
      OP_MULM:  res = mulm_res;
      OP_DIV:   begin res = div0 ? ALL1 : quo[W-1:0]; ovf = div0 || q_ovf; end
      OP_REM:   begin res = div0 ? a : rem_v; ovf = div0; end
      OP_SLT:   res = lt ? ALL1 : '0;
      OP_CMP:   begin res = dif_ab[W-1:0]; cy = dif_ab[W]; end
      default:  ;
    endcase
  end

  always_comb begin
    if (op == OP_DIV && b == '0)
      p_div0_flag_r6: assert (res == ALL1 && ovf) else $error("div by zero");
    if (op == OP_SLT)
      p_slt_mask_r11: assert ((res == ALL1 || res == '0) && !ovf) else $error("slt");
    if (op == OP_CMP)
      p_cmp_no_ovf_r12: assert (!ovf) else $error("cmp overflow");
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]         b,
  input  logic [$clog2(W)-1:0] amt,
  input  logic [4:0]           op,
  output logic [W-1:0]         res,
  output logic                 ovf,
  output logic                 cy
);
  localparam int SW = $clog2(W);
  localparam int PW = 2 * W;

  logic [W:0]    lsh, rsh;
  logic signed [W:0] ars;
  logic [W-1:0]  rol_v, ror_v;
  logic [PW-1:0] sl;
  logic          ashl_ovf;

  assign lsh   = {1'b0, b} << amt;                // bit W = last bit out
  assign rsh   = {b, 1'b0} >> amt;                // bit 0 = last bit out
  assign ars   = $signed({b, 1'b0}) >>> amt;
  assign rol_v = (b << amt) | (b >> (W - int'(amt)));
  assign ror_v = (b >> amt) | (b << (W - int'(amt)));
  assign sl    = {{W{b[W-1]}}, b} << amt;
  assign ashl_ovf = !((&sl[PW-1:W-1]) || !(|sl[PW-1:W-1]));

  always_comb begin
    res = '0; ovf = 1'b0; cy = 1'b0;
    unique case (op)
      OP_SHL:  begin res = lsh[W-1:0]; cy = lsh[W]; end
      OP_SHR:  begin res = rsh[W:1];   cy = rsh[0]; end
      OP_ROL:  res = rol_v;
      OP_ROR:  res = ror_v;
      OP_ASHL: begin res = sl[W-1:0]; ovf = ashl_ovf; cy = lsh[W]; end
      OP_ASHR: begin res = ars[W:1];  cy = ars[0]; end
      default: ;
    endcase
  end

  always_comb begin
    if (op == OP_ROL || op == OP_ROR)
      p_rot_no_carry_r8: assert (!cy && $countones(res) == $countones(b)) else $error("rotate");
    if (op == OP_ASHR && amt == SW'(W-1))
      p_ashr_sign_r9: assert (res == {W{b[W-1]}}) else $error("ashr sign");
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [4:0]   op,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_PASS: res = a;
      OP_NOT:  res = ~a;
      OP_AND:  res = a & b;
      OP_NAND: res = ~(a & b);
      OP_OR:   res = a | b;
      OP_NOR:  res = ~(a | b);
      OP_XOR:  res = a ^ b;
      OP_XNOR: res = ~(a ^ b);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu16_crypto.sv
module alu16_crypto
  import alu16_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [4:0]    op_i,
  input  logic [SW-1:0] shamt_i,
  output logic [W-1:0]  result_o,
  output logic          ovf_o,
  output logic          zero_o,
  output logic          carry_o
);
  logic [W-1:0] ar_res, sh_res, lg_res;
  logic         ar_ovf, ar_cy, sh_ovf, sh_cy;
  alu_unit_e    unit;

  assign unit = unit_of(op_i);

  alu16_arith #(.W(W)) u_arith (
    .a(a_i), .b(b_i), .op(op_i), .res(ar_res), .ovf(ar_ovf), .cy(ar_cy));

  alu16_shift #(.W(W)) u_shift (
    .b(b_i), .amt(shamt_i), .op(op_i), .res(sh_res), .ovf(sh_ovf), .cy(sh_cy));

  alu16_logic #(.W(W)) u_logic (
    .a(a_i), .b(b_i), .op(op_i), .res(lg_res));

  always_comb begin
    unique case (unit)
      U_ARITH: begin result_o = ar_res; ovf_o = ar_ovf; carry_o = ar_cy; end
      U_SHIFT: begin result_o = sh_res; ovf_o = sh_ovf; carry_o = sh_cy; end
      U_LOGIC: begin result_o = lg_res; ovf_o = 1'b0;   carry_o = 1'b0;  end
      default: begin result_o = '0;     ovf_o = 1'b0;   carry_o = 1'b0;  end
    endcase
  end

  assign zero_o = (result_o == '0);

  always_comb begin
    if (op_i == OP_ADDM)
      p_addm_no_ovf_r2: assert (!ovf_o) else $error("addm overflow");
    if (op_i == OP_ADINV)
      p_adinv_sum_r3: assert (W'(result_o + b_i) == '0 && !ovf_o) else $error("adinv");
    if (op_i == OP_MULM)
      p_mulm_no_ovf_r5: assert (!ovf_o) else $error("mulm overflow");
    if (op_i >= 5'd26)
      p_reserved_quiet_r13: assert (zero_o && !ovf_o && !carry_o) else $error("reserved");
    if (unit == U_LOGIC)
      p_logic_flags_r10: assert (!ovf_o && !carry_o) else $error("logic flags");
  end
endmodule

// File: tb/tb_alu16_crypto.sv
module tb_alu16_crypto;
  logic        clk = 1'b0;
  logic [15:0] a, b, res;
  logic [4:0]  op;
  logic [3:0]  amt;
  logic        ovf, zero, cy;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu16_crypto dut (
    .a_i(a), .b_i(b), .op_i(op), .shamt_i(amt),
    .result_o(res), .ovf_o(ovf), .zero_o(zero), .carry_o(cy));

  task automatic run(input string tag, input int o, input logic [15:0] va,
                     input logic [15:0] vb, input int sh,
                     input logic [15:0] er, input logic eo, input logic ec);
    @(negedge clk);
    op = 5'(o); a = va; b = vb; amt = 4'(sh);
    #1;
    n_chk++;
    if (res !== er || ovf !== eo || cy !== ec || zero !== (er == 16'h0)) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h ovf=%b cy=%b z=%b, exp res=%h ovf=%b cy=%b z=%b",
               tag, o, va, vb, sh, res, ovf, cy, zero, er, eo, ec, (er == 16'h0));
    end
  endtask

  task automatic t_idle();       // R14 zero flag on first applied state
    run("R14", 0, 16'h0000, 16'h0000, 0, 16'h0000, 0, 0);
  endtask

  task automatic t_signed_basic();
    run("R1", 0, 16'h7FFF, 16'h0001, 0, 16'h8000, 1, 0);
    run("R1", 0, 16'hFFFF, 16'h0001, 0, 16'h0000, 0, 1);
    run("R1", 2, 16'h8000, 16'h0001, 0, 16'h7FFF, 1, 0);
    run("R1", 2, 16'h0000, 16'h0001, 0, 16'hFFFF, 0, 1);
    run("R1", 1, 16'h8000, 16'h0000, 0, 16'h7FFF, 1, 0);
    run("R1", 1, 16'h0000, 16'h0000, 0, 16'hFFFF, 0, 1);
    run("R1", 3, 16'hFFFF, 16'h0000, 0, 16'h0000, 0, 1);
    run("R1", 3, 16'h7FFF, 16'h0000, 0, 16'h8000, 1, 0);
  endtask

  task automatic t_modular();
    run("R2", 4, 16'h8000, 16'h8000, 0, 16'h0000, 0, 1);
    run("R2", 4, 16'h7FFF, 16'h0001, 0, 16'h8000, 0, 0);
    run("R3", 5, 16'h5555, 16'h0001, 0, 16'hFFFF, 0, 0);
    run("R3", 5, 16'h5555, 16'h0000, 0, 16'h0000, 0, 0);
    run("R3", 5, 16'h0000, 16'h1234, 0, 16'hEDCC, 0, 0);
    run("R5", 7, 16'h0000, 16'h0000, 0, 16'h0001, 0, 0);
    run("R5", 7, 16'h0000, 16'h0001, 0, 16'h0000, 0, 0);
    run("R5", 7, 16'h8000, 16'h0002, 0, 16'h0000, 0, 0);
    run("R5", 7, 16'h0003, 16'h0005, 0, 16'h000F, 0, 0);
    run("R5", 7, 16'hFFFF, 16'hFFFF, 0, 16'h0004, 0, 0);
    run("R5", 7, 16'h0002, 16'h8001, 0, 16'h0001, 0, 0);
  endtask

  task automatic t_mul_div();
    run("R4", 6, 16'h0100, 16'h0100, 0, 16'h0000, 1, 0);
    run("R4", 6, 16'hFFFF, 16'hFFFF, 0, 16'h0001, 0, 0);
    run("R4", 6, 16'h0080, 16'h0100, 0, 16'h8000, 1, 0);
    run("R4", 6, 16'hFF80, 16'h0100, 0, 16'h8000, 0, 0);
    run("R6", 8, 16'hFFF9, 16'h0002, 0, 16'hFFFD, 0, 0);
    run("R6", 9, 16'hFFF9, 16'h0002, 0, 16'hFFFF, 0, 0);
    run("R6", 8, 16'h0007, 16'h0000, 0, 16'hFFFF, 1, 0);
    run("R6", 9, 16'h0007, 16'h0000, 0, 16'h0007, 1, 0);
    run("R6", 8, 16'h8000, 16'hFFFF, 0, 16'h8000, 1, 0);
    run("R6", 9, 16'h0064, 16'h0007, 0, 16'h0002, 0, 0);
  endtask

  task automatic t_shifts();
    run("R7", 10, 16'h0000, 16'h8001, 1,  16'h0002, 0, 1);
    run("R7", 10, 16'h0000, 16'h8001, 0,  16'h8001, 0, 0);
    run("R7", 11, 16'h0000, 16'h8001, 4,  16'h0800, 0, 0);
    run("R7", 11, 16'h0000, 16'h000F, 4,  16'h0000, 0, 1);
    run("R8", 12, 16'h0000, 16'h8001, 4,  16'h0018, 0, 0);
    run("R8", 13, 16'h0000, 16'h8001, 4,  16'h1800, 0, 0);
    run("R8", 12, 16'h0000, 16'hA5C3, 0,  16'hA5C3, 0, 0);
    run("R9", 15, 16'h0000, 16'h8000, 15, 16'hFFFF, 0, 0);
    run("R9", 15, 16'h0000, 16'h7FF1, 1,  16'h3FF8, 0, 1);
    run("R9", 14, 16'h0000, 16'h4000, 1,  16'h8000, 1, 0);
    run("R9", 14, 16'h0000, 16'hFFFF, 15, 16'h8000, 0, 1);
    run("R9", 14, 16'h0000, 16'hC000, 1,  16'h8000, 0, 1);
  endtask

  task automatic t_logic();
    run("R10", 16, 16'hF0F0, 16'hFF00, 0, 16'hF0F0, 0, 0);
    run("R10", 17, 16'hF0F0, 16'hFF00, 0, 16'h0F0F, 0, 0);
    run("R10", 18, 16'hF0F0, 16'hFF00, 0, 16'hF000, 0, 0);
    run("R10", 19, 16'hF0F0, 16'hFF00, 0, 16'h0FFF, 0, 0);
    run("R10", 20, 16'hF0F0, 16'hFF00, 0, 16'hFFF0, 0, 0);
    run("R10", 21, 16'hF0F0, 16'hFF00, 0, 16'h000F, 0, 0);
    run("R10", 22, 16'hF0F0, 16'hFF00, 0, 16'h0FF0, 0, 0);
    run("R10", 23, 16'hF0F0, 16'hFF00, 0, 16'hF00F, 0, 0);
  endtask

  task automatic t_compare();
    run("R11", 24, 16'h8000, 16'h7FFF, 0, 16'hFFFF, 0, 0);
    run("R11", 24, 16'h7FFF, 16'h8000, 0, 16'h0000, 0, 0);
    run("R11", 24, 16'h0001, 16'h0002, 0, 16'hFFFF, 0, 0);
    run("R11", 24, 16'h0005, 16'h0005, 0, 16'h0000, 0, 0);
    run("R12", 25, 16'h8000, 16'h0001, 0, 16'h7FFF, 0, 0);
    run("R12", 25, 16'h0000, 16'h0001, 0, 16'hFFFF, 0, 1);
  endtask

  task automatic t_reserved();
    for (int o = 26; o < 32; o++)
      run("R13", o, 16'h1234, 16'hFFFF, 3, 16'h0000, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; op = '0; amt = '0;
    t_idle();
    t_signed_basic();
    t_modular();
    t_mul_div();
    t_shifts();
    t_logic();
    t_compare();
    t_reserved();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule